// File: doc/BRIEF.md
# Slot-Aware Next-Bundle Address Predictor

This block sits in the fetch stage of a wide-issue front end that fetches one instruction bundle per cycle. Given the address of the bundle being fetched, it gives three results in the same cycle. The first is a direction guess: does any branch in the bundle redirect fetch. The second is the issue slot expected to hold that branch. The third is the address to fetch next.

The direction guess comes from a table of two-bit counters. The table is indexed by the bundle index XORed with a global outcome history. Each counter entry also remembers the slot of the last taken branch that trained it. That slot, joined with the low bundle-index bits, selects a row of a direct-mapped target cache. Branches in different slots of one bundle therefore keep their own targets.

The fetch logic carries the predicted values and the history snapshot down the pipe. Execute hands them back on the resolve port together with the real outcome. All tables and the history register are trained there, never at fetch. A registered misprediction flag reports any disagreement.

Top module: `bundle_nextpc_pred`

## Requirements
- R1: After a synchronous active-low reset, every counter is weakly not-taken (2'b01), the history is zero, every target entry is invalid and `mispredict` is 0. As a result every bundle predicts not-taken, slot 0 and the sequential address.
- R2: The counter entry used for a prediction is the one at (bundle index low bits) XOR (current history), where bundle index = `fetch_pc >> log2(BUNDLE_BYTES)`. The entry trained on resolve is the one at (`res_bidx` low bits) XOR `res_ghist`.
- R3: A counter predicts taken when its bit 1 is set. A resolve moves it up by one if taken and down by one if not taken, saturating at 2'b00 and 2'b11.
- R4: `pred_slot` equals the slot stored in the selected counter entry when `pred_taken` is 1, and is 0 otherwise. The stored slot is replaced by `res_slot` only on a taken resolve.
- R5: The target row is {bundle index low bits, stored slot}, and the tag is the remaining upper bundle-index bits. A taken resolve writes the valid bit, tag and `res_target` to the row built from `res_bidx` and `res_slot`. When the prediction is taken and the row hits, `pred_next_pc` is the stored target.
- R6: When the prediction is not taken, or the target row misses, `pred_next_pc` is `fetch_pc + BUNDLE_BYTES`.
- R7: On every resolve the history shifts left by one and takes `res_taken` into bit 0. `fetch_ghist` shows the current history.
- R8: `mispredict` rises one cycle after a resolve whose outcome differs from the carried prediction. It is set when the direction differs. It is also set when the branch is taken and either the slot or `res_target` differs from the carried next address. Otherwise it is 0.
- R9: While `res_valid` is 0, the resolve fields have no effect on any table, the history or `mispredict`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | PC_W | Address of the bundle being fetched |
| pred_taken | output | 1 | Bundle predicted to redirect fetch |
| pred_slot | output | SLOT_W | Predicted slot of the taken branch |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| fetch_ghist | output | HIST_W | History snapshot to carry with the bundle |
| res_valid | input | 1 | A resolved bundle is presented |
| res_bidx | input | PC_W-OFF_W | Bundle index of the resolved bundle |
| res_ghist | input | HIST_W | History snapshot carried from fetch |
| res_taken | input | 1 | A branch in the bundle was taken |
| res_slot | input | SLOT_W | Slot of the taken branch |
| res_target | input | PC_W | Actual taken target |
| res_pred_taken | input | 1 | Carried direction prediction |
| res_pred_slot | input | SLOT_W | Carried slot prediction |
| res_pred_next_pc | input | PC_W | Carried next-address prediction |
| mispredict | output | 1 | Registered misprediction flag |

## Verification
The three fetch results are combinational, so they are due in the same cycle as `fetch_pc`. The bench drives the address just after a falling edge and samples one nanosecond later. Training, the history shift and `mispredict` take effect at the next rising edge. The bench presents the resolve after sampling the prediction, updates its own table model at that rising edge, and reads `mispredict` at the following falling edge. The next step's prediction, sampled right after, is what shows whether training happened or, after an invalid resolve, was correctly skipped.

// File: rtl/bnp_pkg.sv
// Package: shared counter encoding and saturating update for the
// next-bundle predictor. Assumes two-bit counters throughout.
package bnp_pkg;

    localparam int unsigned DEF_PC_W         = 32;
    localparam int unsigned DEF_DIR_ENTRIES  = 2048;
    localparam int unsigned DEF_BTB_ENTRIES  = 512;
    localparam int unsigned DEF_SLOTS        = 4;
    localparam int unsigned DEF_BUNDLE_BYTES = 16;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    // Saturating step of a two-bit counter toward the resolved outcome.
    function automatic logic [1:0] ctr_next(input logic [1:0] cur, input logic tk);
        logic [1:0] nxt;
        if (tk) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
        else    nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/bnp_hist_reg.sv
// Global outcome history: a shift register that takes one resolved
// direction bit per resolve. Assumes bit 0 is the newest outcome.
module bnp_hist_reg #(
    parameter int unsigned HIST_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_q;

    // Clear on reset, otherwise shift in the outcome on each resolve.
    always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], bit_in};
    end

    assign hist = hist_q;

endmodule

// File: rtl/bnp_dir_table.sv
// Direction table: one two-bit counter plus one remembered slot per entry.
// One combinational read port for fetch and one write port for resolve.
// Assumes a read and a write in one cycle returns the old contents.
module bnp_dir_table
    import bnp_pkg::*;
#(
    parameter int unsigned ENTRIES = 2048,
    parameter int unsigned SLOT_W  = 2,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_taken,
    output logic [SLOT_W-1:0] rd_slot,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_taken,
    input  logic [SLOT_W-1:0] wr_slot
);

    logic [1:0]        ctr_q  [ENTRIES];
    logic [SLOT_W-1:0] slot_q [ENTRIES];

    // Counters reset to weakly not-taken, then step toward each outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(ENTRIES); i++) ctr_q[i] <= CTR_WEAK_NT;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_next(ctr_q[wr_idx], wr_taken);
        end
    end

    // Remembered slot is cleared on reset and replaced only by taken resolves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(ENTRIES); i++) slot_q[i] <= '0;
        end else if (wr_en && wr_taken) begin
            slot_q[wr_idx] <= wr_slot;
        end
    end

    // Read port: upper counter bit is the direction guess.
    always_comb begin
        rd_taken = ctr_q[rd_idx][1];
        rd_slot  = slot_q[rd_idx];
    end

endmodule

// File: rtl/bnp_target_buf.sv
// Direct-mapped target cache with a valid bit and tag per row.
// Only valid bits are reset; tag and target storage needs no reset.
module bnp_target_buf #(
    parameter int unsigned ENTRIES = 512,
    parameter int unsigned TAG_W   = 21,
    parameter int unsigned PC_W    = 32,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target
);

    logic             vld_q [ENTRIES];
    logic [TAG_W-1:0] tag_q [ENTRIES];
    logic [PC_W-1:0]  tgt_q [ENTRIES];

    // Valid bits clear on reset and set on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(ENTRIES); i++) vld_q[i] <= 1'b0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and target storage, written alongside the valid bit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    // Lookup: hit when the row is valid and its tag matches.
    always_comb begin
        rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_target = tgt_q[rd_idx];
    end

endmodule

// File: rtl/bundle_nextpc_pred.sv
// Top: next-bundle address predictor. Fetch-side outputs are combinational
// from fetch_pc and the stored state. All training happens on the resolve
// port. Assumes fetch carries the prediction and history down to execute.
// Requires HIST_W <= bundle-index width, SLOT_W < BTB index width, HIST_W >= 2.
module bundle_nextpc_pred
    import bnp_pkg::*;
#(
    parameter int unsigned PC_W         = DEF_PC_W,
    parameter int unsigned DIR_ENTRIES  = DEF_DIR_ENTRIES,
    parameter int unsigned BTB_ENTRIES  = DEF_BTB_ENTRIES,
    parameter int unsigned SLOTS        = DEF_SLOTS,
    parameter int unsigned BUNDLE_BYTES = DEF_BUNDLE_BYTES,
    localparam int unsigned HIST_W      = $clog2(DIR_ENTRIES),
    localparam int unsigned SLOT_W      = $clog2(SLOTS),
    localparam int unsigned OFF_W       = $clog2(BUNDLE_BYTES),
    localparam int unsigned BIDX_W      = PC_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   fetch_pc,
    output logic              pred_taken,
    output logic [SLOT_W-1:0] pred_slot,
    output logic [PC_W-1:0]   pred_next_pc,
    output logic [HIST_W-1:0] fetch_ghist,
    input  logic              res_valid,
    input  logic [BIDX_W-1:0] res_bidx,
    input  logic [HIST_W-1:0] res_ghist,
    input  logic              res_taken,
    input  logic [SLOT_W-1:0] res_slot,
    input  logic [PC_W-1:0]   res_target,
    input  logic              res_pred_taken,
    input  logic [SLOT_W-1:0] res_pred_slot,
    input  logic [PC_W-1:0]   res_pred_next_pc,
    output logic              mispredict
);

    localparam int unsigned BTB_IDX_W = $clog2(BTB_ENTRIES);
    localparam int unsigned ROW_W     = BTB_IDX_W - SLOT_W;
    localparam int unsigned TAG_W     = BIDX_W - ROW_W;

    logic [HIST_W-1:0]    ghist;
    logic [BIDX_W-1:0]    f_bidx;
    logic [HIST_W-1:0]    f_dir_idx;
    logic [HIST_W-1:0]    r_dir_idx;
    logic                 dir_taken;
    logic [SLOT_W-1:0]    dir_slot;
    logic [BTB_IDX_W-1:0] f_btb_idx;
    logic [BTB_IDX_W-1:0] r_btb_idx;
    logic                 btb_hit;
    logic [PC_W-1:0]      btb_target;
    logic [PC_W-1:0]      seq_pc;
    logic                 miss_now;
    logic                 mispredict_q;

    // Fetch-side index formation: gshare index, target row and fall-through.
    always_comb begin
        f_bidx    = fetch_pc[PC_W-1:OFF_W];
        f_dir_idx = f_bidx[HIST_W-1:0] ^ ghist;
        f_btb_idx = {f_bidx[ROW_W-1:0], dir_slot};
        seq_pc    = fetch_pc + PC_W'(BUNDLE_BYTES);
    end

    // Resolve-side indices rebuilt from the carried history and actual slot.
    always_comb begin
        r_dir_idx = res_bidx[HIST_W-1:0] ^ res_ghist;
        r_btb_idx = {res_bidx[ROW_W-1:0], res_slot};
    end

    bnp_hist_reg #(
        .HIST_W  (HIST_W)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(res_valid),
        .bit_in  (res_taken),
        .hist    (ghist)
    );

    bnp_dir_table #(
        .ENTRIES (DIR_ENTRIES),
        .SLOT_W  (SLOT_W)
    ) u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (f_dir_idx),
        .rd_taken(dir_taken),
        .rd_slot (dir_slot),
        .wr_en   (res_valid),
        .wr_idx  (r_dir_idx),
        .wr_taken(res_taken),
        .wr_slot (res_slot)
    );

    bnp_target_buf #(
        .ENTRIES  (BTB_ENTRIES),
        .TAG_W    (TAG_W),
        .PC_W     (PC_W)
    ) u_btb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (f_btb_idx),
        .rd_tag   (f_bidx[BIDX_W-1:ROW_W]),
        .rd_hit   (btb_hit),
        .rd_target(btb_target),
        .wr_en    (res_valid && res_taken),
        .wr_idx   (r_btb_idx),
        .wr_tag   (res_bidx[BIDX_W-1:ROW_W]),
        .wr_target(res_target)
    );

    // Fetch outputs: redirect only on a taken guess that hits the target cache.
    always_comb begin
        pred_taken   = dir_taken;
        pred_slot    = dir_taken ? dir_slot : '0;
        pred_next_pc = (dir_taken && btb_hit) ? btb_target : seq_pc;
        fetch_ghist  = ghist;
    end

    // Compare the resolved outcome against what travelled with the bundle.
    always_comb begin
        miss_now = 1'b0;
        if (res_taken != res_pred_taken)
            miss_now = 1'b1;
        else if (res_taken && ((res_slot != res_pred_slot) ||
                               (res_target != res_pred_next_pc)))
            miss_now = 1'b1;
    end

    // Register the misprediction flag one cycle after the resolve.
    always_ff @(posedge clk) begin
        if (!rst_n) mispredict_q <= 1'b0;
        else        mispredict_q <= res_valid && miss_now;
    end

    assign mispredict = mispredict_q;

endmodule

// File: rtl/bnp_chk.sv
// Checker: temporal properties on the predictor ports, bound to the top.
module bnp_chk #(
    parameter int unsigned PC_W         = 32,
    parameter int unsigned HIST_W       = 11,
    parameter int unsigned SLOT_W       = 2,
    parameter int unsigned BUNDLE_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   fetch_pc,
    input logic              pred_taken,
    input logic [SLOT_W-1:0] pred_slot,
    input logic [PC_W-1:0]   pred_next_pc,
    input logic [HIST_W-1:0] fetch_ghist,
    input logic              res_valid,
    input logic              res_taken,
    input logic              res_pred_taken,
    input logic              mispredict
);

    // R6
    seq_on_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_next_pc == fetch_pc + PC_W'(BUNDLE_BYTES));

    // R4
    slot_zero_on_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_slot == '0);

    // R7
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> fetch_ghist == {$past(fetch_ghist[HIST_W-2:0]), $past(res_taken)});

    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(fetch_ghist));

    // R9
    no_flag_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> !mispredict);

    // R8
    dir_miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_taken != res_pred_taken)) |=> mispredict);

endmodule

bind bundle_nextpc_pred bnp_chk #(
    .PC_W        (PC_W),
    .HIST_W      (HIST_W),
    .SLOT_W      (SLOT_W),
    .BUNDLE_BYTES(BUNDLE_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_pc      (fetch_pc),
    .pred_taken    (pred_taken),
    .pred_slot     (pred_slot),
    .pred_next_pc  (pred_next_pc),
    .fetch_ghist   (fetch_ghist),
    .res_valid     (res_valid),
    .res_taken     (res_taken),
    .res_pred_taken(res_pred_taken),
    .mispredict    (mispredict)
);

// File: tb/sim_bundle_nextpc_pred.sv
`timescale 1ns/1ps
// Bench: small configuration (16-bit PC, 16 counters, 16 target rows,
// 4 slots, 16-byte bundles) swept against an arithmetic table model.
module sim_bundle_nextpc_pred;

    localparam int PC_W = 16;
    localparam int HW   = 4;
    localparam int SW   = 2;
    localparam int BW   = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic          pred_taken;
    logic [SW-1:0] pred_slot;
    logic [PC_W-1:0] pred_next_pc;
    logic [HW-1:0] fetch_ghist;
    logic          res_valid = 1'b0;
    logic [BW-1:0] res_bidx = '0;
    logic [HW-1:0] res_ghist = '0;
    logic          res_taken = 1'b0;
    logic [SW-1:0] res_slot = '0;
    logic [PC_W-1:0] res_target = '0;
    logic          res_pred_taken = 1'b0;
    logic [SW-1:0] res_pred_slot = '0;
    logic [PC_W-1:0] res_pred_next_pc = '0;
    logic          mispredict;

    always #2.5 clk = ~clk;

    bundle_nextpc_pred #(
        .PC_W(16), .DIR_ENTRIES(16), .BTB_ENTRIES(16), .SLOTS(4), .BUNDLE_BYTES(16)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_slot(pred_slot),
        .pred_next_pc(pred_next_pc), .fetch_ghist(fetch_ghist),
        .res_valid(res_valid), .res_bidx(res_bidx), .res_ghist(res_ghist),
        .res_taken(res_taken), .res_slot(res_slot), .res_target(res_target),
        .res_pred_taken(res_pred_taken), .res_pred_slot(res_pred_slot),
        .res_pred_next_pc(res_pred_next_pc), .mispredict(mispredict)
    );

    // Reference model state
    logic [1:0]      m_ctr  [16];
    logic [SW-1:0]   m_slot [16];
    logic            m_bv   [16];
    logic [9:0]      m_btag [16];
    logic [PC_W-1:0] m_btgt [16];
    logic [HW-1:0]   m_ghr;
    logic            prev_idle;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_ctr[i] = 2'b01; m_slot[i] = '0; m_bv[i] = 1'b0;
            m_btag[i] = '0; m_btgt[i] = '0;
        end
        m_ghr = '0;
        prev_idle = 1'b0;
    endtask

    // One step, entered at a falling edge: fetch, check, resolve, check flag.
    task automatic step(input logic [PC_W-1:0] pc, input bit rv, input bit tk,
                        input logic [SW-1:0] sl, input logic [PC_W-1:0] tg);
        logic [BW-1:0]   b;
        logic [HW-1:0]   di;
        logic [3:0]      bi;
        bit              e_tk, e_hit, e_mis;
        logic [SW-1:0]   e_sl;
        logic [PC_W-1:0] e_nx;
        string           tg_dir, tg_nx;
        b    = pc[15:4];
        di   = b[3:0] ^ m_ghr;
        e_tk = m_ctr[di][1];
        e_sl = e_tk ? m_slot[di] : '0;
        bi   = {b[1:0], m_slot[di]};
        e_hit = m_bv[bi] && (m_btag[bi] == b[11:2]);
        e_nx = (e_tk && e_hit) ? m_btgt[bi] : pc + 16'd16;
        tg_dir = prev_idle ? "R9/R3" : "R2/R3";
        tg_nx  = prev_idle ? "R9/R5" : ((e_tk && e_hit) ? "R5" : "R6");
        fetch_pc = pc;
        #1;
        chk(pred_taken == e_tk, tg_dir, "pred_taken", int'(pred_taken), int'(e_tk));
        chk(pred_slot == e_sl, "R4", "pred_slot", int'(pred_slot), int'(e_sl));
        chk(pred_next_pc == e_nx, tg_nx, "pred_next_pc", int'(pred_next_pc), int'(e_nx));
        chk(fetch_ghist == m_ghr, "R7", "fetch_ghist", int'(fetch_ghist), int'(m_ghr));
        res_valid = rv; res_bidx = b; res_ghist = fetch_ghist;
        res_taken = tk; res_slot = sl; res_target = tg;
        res_pred_taken = pred_taken; res_pred_slot = pred_slot;
        res_pred_next_pc = pred_next_pc;
        e_mis = rv && ((tk != e_tk) || (tk && ((sl != e_sl) || (tg != e_nx))));
        @(posedge clk);
        if (rv) begin
            m_ctr[di] = tk ? ((m_ctr[di] == 2'b11) ? 2'b11 : m_ctr[di] + 2'd1)
                           : ((m_ctr[di] == 2'b00) ? 2'b00 : m_ctr[di] - 2'd1);
            if (tk) begin
                m_slot[di] = sl;
                m_bv[{b[1:0], sl}]   = 1'b1;
                m_btag[{b[1:0], sl}] = b[11:2];
                m_btgt[{b[1:0], sl}] = tg;
            end
            m_ghr = {m_ghr[2:0], tk};
        end
        prev_idle = !rv;
        @(negedge clk);
        chk(mispredict == e_mis, rv ? "R8" : "R9", "mispredict",
            int'(mispredict), int'(e_mis));
        res_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state over many bundle addresses
        chk(mispredict == 1'b0, "R1", "mispredict after reset", int'(mispredict), 0);
        chk(fetch_ghist == '0, "R1", "history after reset", int'(fetch_ghist), 0);
        for (int a = 0; a < 64; a++) begin
            fetch_pc = 16'(a * 48 + (a % 16));
            #1;
            chk(pred_taken == 1'b0, "R1", "pred_taken after reset", int'(pred_taken), 0);
            chk(pred_slot == '0, "R1", "pred_slot after reset", int'(pred_slot), 0);
            chk(pred_next_pc == fetch_pc + 16'd16, "R1", "next after reset",
                int'(pred_next_pc), int'(fetch_pc + 16'd16));
        end
        @(negedge clk);
        // R3/R4/R5: one bundle trained taken in slot 2 until saturation
        for (int k = 0; k < 8; k++) step(16'h0120, 1, 1, 2'd2, 16'h3A40);
        // R3: trained back down with not-taken outcomes
        for (int k = 0; k < 6; k++) step(16'h0120, 1, 0, 2'd0, 16'h0000);
        // R5: two slots of one bundle keep separate targets
        for (int k = 0; k < 6; k++) step(16'h0200, 1, 1, 2'd1, 16'h1110);
        for (int k = 0; k < 6; k++) step(16'h0200, 1, 1, 2'd3, 16'h2220);
        // R9: idle resolves with garbage fields
        for (int k = 0; k < 4; k++) step(16'h0200, 0, 1, 2'd0, 16'hFFF0);
        // Mixed sweep over aliasing bundles
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            logic [2:0]  sel;
            logic [BW-1:0] bx;
            bit          rv, tk;
            logic [SW-1:0] sl;
            logic [PC_W-1:0] tg;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sel = lfsr[2:0];
            bx  = {1'b0, sel[2], 7'h00, sel[2], sel[1:0]};
            rv  = (lfsr[12:10] != 3'd0);
            tk  = (sel == 3'd0) ? 1'b1 : (sel == 3'd1) ? 1'b0 : lfsr[6];
            sl  = (sel == 3'd0) ? 2'd1 : lfsr[5:4];
            tg  = {bx ^ 12'h5A5 ^ {10'b0, sl}, 4'h0} + ((lfsr[9:7] == 3'd0) ? 16'd16 : 16'd0);
            step({bx, lfsr[3], 3'b000}, rv, tk, sl, tg);
        end
        finish_run();
    end

endmodule